// File: doc/BRIEF.md
# Linear-Light Colour Correction Chain

This block corrects the gamut of an 8-bit-per-channel sRGB pixel stream. It converts each incoming code to a 12-bit linear-light value and mixes the three linear channels through a programmable 3x3 matrix. The result is rounded, limited to the 12-bit range and encoded back into an 8-bit sRGB code. Because the intermediate path keeps 12 bits, the darkest sRGB steps stay distinct and are not merged together when the gamut is remapped.

The stream moves at one pixel per clock with no back-pressure. This rate covers a 960x540, 60 frames/s raster at about 37.8 MHz. A valid strobe and start-of-frame and end-of-line markers travel with every pixel and come out with it. Matrix coefficients are written through a small write port into a shadow set. That set is copied into the working set when the next start-of-frame pixel arrives, so a frame is never processed with a mix of old and new coefficients. Both curve tables are computed during elaboration and are held as constant ROM contents.

Top module: `linear_color_chain`

## Requirements
- R1: Each output channel equals enc(clamp(round(sum over inputs of coef x dec(in)))), applied in that order. dec maps code c to round(4095 x L), where x = c/255 and L = x/12.92 when x <= 0.04045, else ((x+0.055)/1.055)^2.4. enc maps v to round(255 x E), where y = v/4095 and E = 12.92y when y <= 0.0031308, else 1.055 y^(1/2.4) - 0.055.
- R2: With the identity matrix, input codes 1 to 15 on a channel produce output codes that are non-zero and strictly increasing.
- R3: With the identity matrix, every output channel is within 1 of its input code, for all 256 codes.
- R4: Coefficients are 16-bit two's complement with 12 fractional bits (0x1000 = 1.0). Address row*3+col sets the weight that input channel col gives to output channel row. Channel 0 is red at in_rgb/out_rgb bits 23:16, channel 1 is green at 15:8 and channel 2 is blue at 7:0. After reset the matrix is identity.
- R5: Each matrix sum is rounded by adding 2048 and then shifting arithmetically right by 12. It is then clamped to 0..4095, so large positive sums give 255 and negative sums give 0.
- R6: Coefficient writes only change the shadow set. The shadow set is copied to the working set by a pixel with in_valid and in_sof both high, and that pixel already uses the copied set. A write in the same cycle as that pixel waits for the next start of frame.
- R7: Writes to addresses 9 to 15 are ignored.
- R8: out_valid repeats in_valid exactly 4 cycles later. out_sof and out_eol repeat (in_valid & in_sof) and (in_valid & in_eol) with the same 4-cycle delay.
- R9: The block accepts one pixel per clock, both back to back and with idle gaps between pixels.
- R10: After reset, out_valid, out_sof, out_eol and out_rgb are all 0. out_rgb keeps its last value in every cycle where out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel strobe |
| in_sof | input | 1 | Start-of-frame marker, qualified by in_valid |
| in_eol | input | 1 | End-of-line marker, qualified by in_valid |
| in_rgb | input | 24 | Input pixel {R,G,B}, 8-bit sRGB codes |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 4 | Coefficient index row*3+col |
| coef_wdata | input | 16 | Signed 4.12 coefficient |
| out_valid | output | 1 | Output pixel strobe |
| out_sof | output | 1 | Delayed start-of-frame marker |
| out_eol | output | 1 | Delayed end-of-line marker |
| out_rgb | output | 24 | Corrected pixel {R,G,B} |

## Verification
Every pixel result and its markers are due exactly 4 clock edges after the edge that captures the input. The bench stamps each driven pixel with the cycle count and checks that the output shows up at stamp plus 4, sampling on the falling edge. A coefficient change is due with the first start-of-frame pixel that follows the write. The bench model copies its shadow set at the moment it drives that pixel, so each expected value is built from the coefficients the hardware should use at that point. Between outputs, out_rgb is checked on every cycle to confirm it holds its last value.

// File: rtl/lcc_pkg.sv
package lcc_pkg;

  typedef struct packed {
    logic vld;
    logic sof;
    logic eol;
  } mark_t;

  localparam int CURVE_DECODE = 0;
  localparam int CURVE_ENCODE = 1;

  // sRGB code -> linear light, scaled to lin_max and rounded
  function automatic int srgb_to_lin(input int code, input int code_max, input int lin_max);
    real x;
    real y;
    x = real'(code) / real'(code_max);
    if (x <= 0.04045) y = x / 12.92;
    else              y = ((x + 0.055) / 1.055) ** 2.4;
    if (y < 0.0) y = 0.0;
    if (y > 1.0) y = 1.0;
    return $rtoi(y * real'(lin_max) + 0.5);
  endfunction

  // linear light -> sRGB code, scaled to code_max and rounded
  function automatic int lin_to_srgb(input int lin, input int lin_max, input int code_max);
    real x;
    real y;
    x = real'(lin) / real'(lin_max);
    if (x <= 0.0031308) y = 12.92 * x;
    else                y = 1.055 * (x ** (1.0 / 2.4)) - 0.055;
    if (y < 0.0) y = 0.0;
    if (y > 1.0) y = 1.0;
    return $rtoi(y * real'(code_max) + 0.5);
  endfunction

endpackage

// File: rtl/lcc_rom.sv
module lcc_rom #(
  parameter int AW    = 8,
  parameter int DW    = 12,
  parameter int CURVE = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] q
);
  import lcc_pkg::*;

  localparam int DEPTH = 1 << AW;
  localparam int IN_MAX = DEPTH - 1;
  localparam int OUT_MAX = (1 << DW) - 1;

  logic [DW-1:0] rom_mem [DEPTH];
  logic [DW-1:0] rd_d;
  logic [DW-1:0] rd_q;

  // constant contents computed at elaboration
  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      if (CURVE == CURVE_DECODE) rom_mem[i] = DW'(srgb_to_lin(i, IN_MAX, OUT_MAX));
      else                       rom_mem[i] = DW'(lin_to_srgb(i, IN_MAX, OUT_MAX));
    end
  end

  always_comb begin
    rd_d = rd_q;
    if (en) rd_d = rom_mem[addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign q = rd_q;
endmodule

// File: rtl/lcc_coef_bank.sv
module lcc_coef_bank #(
  parameter int NC   = 3,
  parameter int CW   = 16,
  parameter int FRAC = 12,
  parameter int AW   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [AW-1:0]              waddr,
  input  logic [CW-1:0]              wdata,
  input  logic                       swap,
  output logic [NC*NC-1:0][CW-1:0]   act_o
);
  localparam int NK = NC * NC;
  localparam logic [CW-1:0] ONE = CW'(1) << FRAC;

  logic [NK-1:0][CW-1:0] shd_d, shd_q;
  logic [NK-1:0][CW-1:0] act_d, act_q;

  always_comb begin
    shd_d = shd_q;
    act_d = act_q;
    if (swap) act_d = shd_q;
    for (int k = 0; k < NK; k++) begin
      if (we && (waddr == AW'(k))) shd_d[k] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NK; k++) begin
        shd_q[k] <= ((k % (NC + 1)) == 0) ? ONE : '0;
        act_q[k] <= ((k % (NC + 1)) == 0) ? ONE : '0;
      end
    end else begin
      shd_q <= shd_d;
      act_q <= act_d;
    end
  end

  assign act_o = act_q;
endmodule

// File: rtl/lcc_matrix.sv
module lcc_matrix #(
  parameter int NC   = 3,
  parameter int LW   = 12,
  parameter int CW   = 16,
  parameter int FRAC = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      mul_en,
  input  logic                      clp_en,
  input  logic [NC-1:0][LW-1:0]     lin_i,
  input  logic [NC*NC-1:0][CW-1:0]  coef_i,
  output logic [NC-1:0][LW-1:0]     lin_o
);
  localparam int PW = LW + 1 + CW;
  localparam int SW = PW + $clog2(NC);
  localparam logic signed [SW-1:0] HALF = SW'(1) <<< (FRAC - 1);
  localparam logic signed [SW-1:0] LMAX = SW'((1 << LW) - 1);

  logic signed [SW-1:0] acc_d [NC];
  logic signed [SW-1:0] acc_q [NC];
  logic signed [SW-1:0] rnd   [NC];
  logic [NC-1:0][LW-1:0] cl_d, cl_q;

  // stage A: sum of products per output channel
  always_comb begin
    for (int r = 0; r < NC; r++) begin
      acc_d[r] = acc_q[r];
      if (mul_en) begin
        acc_d[r] = '0;
        for (int c = 0; c < NC; c++) begin
          acc_d[r] = acc_d[r] + (SW'($signed({1'b0, lin_i[c]})) * SW'($signed(coef_i[r*NC+c])));
        end
      end
    end
  end

  // stage B: round half up, then clamp to the linear range
  always_comb begin
    for (int r = 0; r < NC; r++) rnd[r] = (acc_q[r] + HALF) >>> FRAC;
  end

  always_comb begin
    cl_d = cl_q;
    if (clp_en) begin
      for (int r = 0; r < NC; r++) begin
        if (rnd[r] < 0)         cl_d[r] = '0;
        else if (rnd[r] > LMAX) cl_d[r] = '1;
        else                    cl_d[r] = rnd[r][LW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NC; r++) acc_q[r] <= '0;
      cl_q <= '0;
    end else begin
      for (int r = 0; r < NC; r++) acc_q[r] <= acc_d[r];
      cl_q <= cl_d;
    end
  end

  assign lin_o = cl_q;
endmodule

// File: rtl/linear_color_chain.sv
module linear_color_chain #(
  parameter int NC   = 3,
  parameter int IW   = 8,
  parameter int LW   = 12,
  parameter int CW   = 16,
  parameter int FRAC = 12,
  parameter int AW   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eol,
  input  logic [NC*IW-1:0] in_rgb,
  input  logic             coef_we,
  input  logic [AW-1:0]    coef_addr,
  input  logic [CW-1:0]    coef_wdata,
  output logic             out_valid,
  output logic             out_sof,
  output logic             out_eol,
  output logic [NC*IW-1:0] out_rgb
);
  import lcc_pkg::*;

  localparam int LAT = 4;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  // marker pipeline, one entry per data stage
  mark_t mk_d [LAT];
  mark_t mk_q [LAT];

  always_comb begin
    mk_d[0] = '{vld: in_valid, sof: in_valid & in_sof, eol: in_valid & in_eol};
    for (int k = 1; k < LAT; k++) mk_d[k] = mk_q[k-1];
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      for (int k = 0; k < LAT; k++) mk_q[k] <= '0;
    end else begin
      for (int k = 0; k < LAT; k++) mk_q[k] <= mk_d[k];
    end
  end

  // coefficients
  logic                      swap;
  logic [NC*NC-1:0][CW-1:0]  act_coef;

  assign swap = in_valid & in_sof;

  lcc_coef_bank #(.NC(NC), .CW(CW), .FRAC(FRAC), .AW(AW)) u_bank (
    .clk   (clk),
    .rst_n (srst_n),
    .we    (coef_we),
    .waddr (coef_addr),
    .wdata (coef_wdata),
    .swap  (swap),
    .act_o (act_coef)
  );

  // data path
  logic [NC-1:0][IW-1:0] in_ch;
  logic [NC-1:0][LW-1:0] lin1;
  logic [NC-1:0][LW-1:0] lin3;
  logic [NC-1:0][IW-1:0] out_ch;

  for (genvar c = 0; c < NC; c++) begin : g_chan
    assign in_ch[c] = in_rgb[(NC-c)*IW-1 -: IW];

    lcc_rom #(.AW(IW), .DW(LW), .CURVE(CURVE_DECODE)) u_dec (
      .clk   (clk),
      .rst_n (srst_n),
      .en    (in_valid),
      .addr  (in_ch[c]),
      .q     (lin1[c])
    );

    lcc_rom #(.AW(LW), .DW(IW), .CURVE(CURVE_ENCODE)) u_enc (
      .clk   (clk),
      .rst_n (srst_n),
      .en    (mk_q[2].vld),
      .addr  (lin3[c]),
      .q     (out_ch[c])
    );

    assign out_rgb[(NC-c)*IW-1 -: IW] = out_ch[c];
  end

  lcc_matrix #(.NC(NC), .LW(LW), .CW(CW), .FRAC(FRAC)) u_mtx (
    .clk    (clk),
    .rst_n  (srst_n),
    .mul_en (mk_q[0].vld),
    .clp_en (mk_q[1].vld),
    .lin_i  (lin1),
    .coef_i (act_coef),
    .lin_o  (lin3)
  );

  assign out_valid = mk_q[LAT-1].vld;
  assign out_sof   = mk_q[LAT-1].sof;
  assign out_eol   = mk_q[LAT-1].eol;
endmodule

// File: rtl/linear_color_chain_chk.sv
module linear_color_chain_chk #(
  parameter int NC = 3,
  parameter int IW = 8,
  parameter int CW = 16
) (
  input logic                      clk,
  input logic                      srst_n,
  input logic                      in_valid,
  input logic                      in_sof,
  input logic                      in_eol,
  input logic                      out_valid,
  input logic                      out_sof,
  input logic                      out_eol,
  input logic [NC*IW-1:0]          out_rgb,
  input logic [NC*NC-1:0][CW-1:0]  act_coef
);
  logic [2:0] cyc_q;
  logic [2:0] cyc_d;

  always_comb cyc_d = (cyc_q == 3'd7) ? cyc_q : cyc_q + 3'd1;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) cyc_q <= '0;
    else         cyc_q <= cyc_d;
  end

  // R8
  lat_valid_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (cyc_q >= 3'd4) |-> (out_valid == $past(in_valid, 4)));

  // R8
  lat_sof_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (cyc_q >= 3'd4) |-> (out_sof == $past(in_valid && in_sof, 4)));

  // R8
  lat_eol_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (cyc_q >= 3'd4) |-> (out_eol == $past(in_valid && in_eol, 4)));

  // R8
  sof_qual_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (out_sof || out_eol) |-> out_valid);

  // R6
  coef_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    ((cyc_q >= 3'd1) && !$past(in_valid && in_sof)) |-> $stable(act_coef));

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    ((cyc_q >= 3'd1) && !out_valid) |-> $stable(out_rgb));
endmodule

bind linear_color_chain linear_color_chain_chk #(.NC(NC), .IW(IW), .CW(CW)) u_chk (
  .clk       (clk),
  .srst_n    (srst_n),
  .in_valid  (in_valid),
  .in_sof    (in_sof),
  .in_eol    (in_eol),
  .out_valid (out_valid),
  .out_sof   (out_sof),
  .out_eol   (out_eol),
  .out_rgb   (out_rgb),
  .act_coef  (act_coef)
);

// File: tb/linear_color_chain_test.sv
module linear_color_chain_test;
  logic        clk;
  logic        rst_n;
  logic        in_valid, in_sof, in_eol;
  logic [23:0] in_rgb;
  logic        coef_we;
  logic [3:0]  coef_addr;
  logic [15:0] coef_wdata;
  logic        out_valid, out_sof, out_eol;
  logic [23:0] out_rgb;

  linear_color_chain uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eol(in_eol),
    .in_rgb(in_rgb), .coef_we(coef_we), .coef_addr(coef_addr), .coef_wdata(coef_wdata),
    .out_valid(out_valid), .out_sof(out_sof), .out_eol(out_eol), .out_rgb(out_rgb)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // independent curve model (R1)
  int dec_t [256];
  int enc_t [4096];

  function automatic int m_dec(input int c);
    real x, l;
    x = c / 255.0;
    if (x <= 0.04045) l = x / 12.92;
    else              l = ((x + 0.055) / 1.055) ** 2.4;
    return $rtoi($floor(l * 4095.0 + 0.5));
  endfunction

  function automatic int m_enc(input int v);
    real y, e;
    y = v / 4095.0;
    if (y <= 0.0031308) e = 12.92 * y;
    else                e = 1.055 * (y ** (1.0 / 2.4)) - 0.055;
    if (e > 1.0) e = 1.0;
    if (e < 0.0) e = 0.0;
    return $rtoi($floor(e * 255.0 + 0.5));
  endfunction

  logic signed [15:0] m_shd [9];
  logic signed [15:0] m_act [9];

  function automatic logic [23:0] m_pix(input logic [23:0] px);
    logic [23:0] res;
    longint acc, rv;
    for (int r = 0; r < 3; r++) begin
      acc = 0;
      for (int c = 0; c < 3; c++)
        acc += longint'(dec_t[px[23-8*c -: 8]]) * longint'(m_act[r*3+c]);
      rv = (acc + 2048) >>> 12;
      if (rv < 0) rv = 0;
      if (rv > 4095) rv = 4095;
      res[23-8*r -: 8] = 8'(enc_t[rv]);
    end
    return res;
  endfunction

  // expected-output queues
  logic [23:0] q_exp [$];
  logic [23:0] q_in  [$];
  logic        q_sof [$];
  logic        q_eol [$];
  int          q_cyc [$];
  bit          q_id  [$];
  string       q_tag [$];

  bit   ident_mode = 0;
  int   red_map [256];
  logic [23:0] last_out = '0;
  bit   mon_on = 0;

  task automatic step(input logic v, input logic s, input logic e, input logic [23:0] px,
                      input logic w, input logic [3:0] wa, input logic [15:0] wd,
                      input string tag);
    in_valid = v; in_sof = s; in_eol = e; in_rgb = px;
    coef_we = w; coef_addr = wa; coef_wdata = wd;
    if (v && s) m_act = m_shd;
    if (v) begin
      q_exp.push_back(m_pix(px)); q_in.push_back(px);
      q_sof.push_back(s); q_eol.push_back(e); q_cyc.push_back(cyc);
      q_id.push_back(ident_mode); q_tag.push_back(tag);
    end
    if (w && wa < 9) m_shd[wa] = wd;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 24'h0, 0, 4'h0, 16'h0, "");
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d, input string tag);
    step(0, 0, 0, 24'h0, 1, a, d, tag);
  endtask

  // monitor
  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid) begin
        if (q_exp.size() == 0) begin
          check(0, "R8", "unexpected out_valid", 1, 0);
        end else begin
          logic [23:0] ex, ip;
          int sc;
          bit idm;
          string tg;
          ex = q_exp.pop_front(); ip = q_in.pop_front(); sc = q_cyc.pop_front();
          idm = q_id.pop_front(); tg = q_tag.pop_front();
          check(out_rgb == ex, tg, "pixel value R1", out_rgb, ex);
          check(cyc == sc + 4, "R8", "latency", cyc - sc, 4);
          check(out_sof == q_sof.pop_front(), "R8", "sof marker", out_sof, !out_sof);
          check(out_eol == q_eol.pop_front(), "R8", "eol marker", out_eol, !out_eol);
          if (idm) begin
            for (int c = 0; c < 3; c++) begin
              int d;
              d = int'(out_rgb[23-8*c -: 8]) - int'(ip[23-8*c -: 8]);
              check(d >= -1 && d <= 1, "R3", "identity round trip", out_rgb[23-8*c -: 8], ip[23-8*c -: 8]);
            end
            red_map[ip[23:16]] = out_rgb[23:16];
          end
        end
        last_out = out_rgb;
      end else begin
        check(out_rgb == last_out, "R10", "hold between pixels", out_rgb, last_out);
        if (q_cyc.size() > 0)
          check(cyc < q_cyc[0] + 4, "R9", "missing output", cyc, q_cyc[0] + 4);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 256; i++) dec_t[i] = m_dec(i);
    for (int i = 0; i < 4096; i++) enc_t[i] = m_enc(i);
    for (int k = 0; k < 9; k++) begin
      m_shd[k] = (k % 4 == 0) ? 16'sh1000 : 16'sh0000;
      m_act[k] = m_shd[k];
    end
    rst_n = 0; in_valid = 0; in_sof = 0; in_eol = 0; in_rgb = '0;
    coef_we = 0; coef_addr = '0; coef_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R10 reset state
    check(out_valid == 0, "R10", "reset out_valid", out_valid, 0);
    check(out_sof == 0 && out_eol == 0, "R10", "reset markers", {out_sof, out_eol}, 0);
    check(out_rgb == 0, "R10", "reset out_rgb", out_rgb, 0);
    mon_on = 1;

    // identity sweep, back to back (R2, R3, R4 reset identity, R9)
    ident_mode = 1;
    for (int c = 0; c < 256; c++)
      step(1, c == 0, (c % 64) == 63, {8'(c), 8'(255 - c), 8'((c * 7) & 255)}, 0, 4'h0, 16'h0, "R4");
    idle(8);
    ident_mode = 0;
    for (int c = 1; c <= 15; c++) begin
      check(red_map[c] != 0, "R2", "low code non-zero", red_map[c], c);
      if (c > 1) check(red_map[c] > red_map[c-1], "R2", "low codes distinct", red_map[c], red_map[c-1] + 1);
    end

    // R6: writes without start of frame stay in the shadow set
    wr(4'd0, 16'h2000, "R6");
    wr(4'd1, 16'hF800, "R6");
    for (int i = 0; i < 12; i++)
      step(1, 0, 0, {8'($urandom_range(0, 255)), 8'($urandom_range(0, 255)), 8'($urandom_range(0, 255))}, 0, 4'h0, 16'h0, "R6");
    // swap pixel with a same-cycle write to a diagonal entry
    step(1, 1, 0, 24'h406080, 1, 4'd4, 16'h0800, "R6");
    for (int i = 0; i < 12; i++)
      step(1, 0, 0, {8'($urandom_range(0, 255)), 8'($urandom_range(0, 255)), 8'($urandom_range(0, 255))}, 0, 4'h0, 16'h0, "R6");
    step(1, 1, 0, 24'h808080, 0, 4'h0, 16'h0, "R6");
    idle(6);

    // R7: out-of-range addresses are ignored
    for (int a = 9; a < 16; a++) wr(4'(a), 16'h0000, "R7");
    step(1, 1, 0, 24'hA0B0C0, 0, 4'h0, 16'h0, "R7");
    for (int i = 0; i < 8; i++)
      step(1, 0, i == 7, {8'($urandom_range(16, 255)), 8'($urandom_range(16, 255)), 8'($urandom_range(16, 255))}, 0, 4'h0, 16'h0, "R7");
    idle(6);

    // R5: clamp high and clamp low
    for (int k = 0; k < 9; k++) wr(4'(k), 16'h7FFF, "R5");
    step(1, 1, 0, 24'hFFFFFF, 0, 4'h0, 16'h0, "R5");
    step(1, 0, 0, 24'h202020, 0, 4'h0, 16'h0, "R5");
    for (int k = 0; k < 9; k++) wr(4'(k), 16'hF000, "R5");
    step(1, 1, 0, 24'hFFFFFF, 0, 4'h0, 16'h0, "R5");
    step(1, 0, 0, 24'h010203, 0, 4'h0, 16'h0, "R5");
    idle(6);
    check(last_out == 24'h000000, "R5", "negative clamp", last_out, 0);

    // random frames with gaps and writes (R1, R5, R6, R9)
    for (int f = 0; f < 6; f++) begin
      int nv;
      nv = 0;
      for (int k = 0; k < 9; k++) wr(4'(k), 16'(int'($urandom_range(0, 20480)) - 8192), "R1");
      for (int p = 0; p < 240; p++) begin
        logic v, w;
        v = ($urandom_range(0, 3) != 0);
        w = ($urandom_range(0, 7) == 0);
        step(v, v && nv == 0, v && (nv % 50) == 49,
             {8'($urandom_range(0, 255)), 8'($urandom_range(0, 255)), 8'($urandom_range(0, 255))},
             w, 4'($urandom_range(0, 15)), 16'(int'($urandom_range(0, 20480)) - 8192), "R9");
        if (v) nv++;
      end
    end
    idle(10);
    check(q_exp.size() == 0, "R8", "all pixels delivered", q_exp.size(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule